// File: doc/BRIEF.md
# Dual-Bank Receive Pipe Controller

This block is the receive half of an inbound data pipe on the host side of a serial bus. Packet bytes from the bus engine go into a packet buffer bank. A packet-end strobe closes the bank and reports whether the packet's CRC was good. The CPU then owns that bank. It reads the bytes through a byte port, acknowledges the interrupt and releases the bank. These are two separate flag clears. When two banks are enabled, the bus side fills bank 0 and bank 1 in turn while the CPU drains the other bank.

CPU ownership is tracked by a three-state machine: `OWN_EMPTY` (the owned bank has no packet), `OWN_READY` (the owned bank is full and the ready flag is set) and `OWN_ACKED` (the owned bank is full and the ready flag has been cleared). The transitions are:
- **fill**: `OWN_EMPTY` to `OWN_READY`, when a packet completes into the owned bank.
- **ack**: `OWN_READY` to `OWN_ACKED`, when software writes 0 to the ready flag.
- **release-reload**: from `OWN_READY` or `OWN_ACKED`, when software writes 0 to the busy flag. The machine goes to `OWN_READY` if the next owned bank already holds a packet, and to `OWN_EMPTY` otherwise.

In isochronous mode, a packet with a bad CRC also raises a separate CRC-error flag. That flag has its own interrupt enable.

Top module: `rxp_pipe_ctrl`

The control word used by `ctl_wdata` and `ctl_rdata` is laid out as follows:

| Bit | Name | Write behaviour |
|---|---|---|
| 0 | ready flag | write 0 clears it |
| 1 | busy flag | write 0 releases the bank |
| 2 | ready interrupt enable | plain read/write |
| 3 | CRC-error flag | write 0 clears it |
| 4 | CRC interrupt enable | plain read/write |

## Requirements
- R1: After reset `ctl_rdata` is 0, `irq` is 0, `rd_bank` is 0, `rd_count` is 0 and `rx_nak` is 0.
- R2: A packet-end into the empty owned bank sets ctl bit 0 (ready) and bit 1 (busy) on the next clock edge, and `rd_count` then equals the number of bytes received.
- R3: `irq` equals (bit 0 AND bit 2) OR (bit 3 AND bit 4) of the control word.
- R4: Writing 0 to bit 0 clears the ready flag only. Bit 1 stays 1, and the bank's data and `rd_count` stay readable.
- R5: Writing 0 to bit 1 while busy releases the owned bank and resets the read pointer to byte 0. In two-bank mode, `rd_bank` also switches to the other bank.
- R6: After a switch, bits 0 and 1 are reloaded from the new bank. Both are 1 if that bank holds a packet, and both are 0 otherwise.
- R7: In two-bank mode, packets fill banks 0, 1, 0, 1 in order. In single-bank mode (`cfg_two_banks`=0), every packet uses bank 0 and `rd_bank` stays 0.
- R8: With `cfg_iso`=1, a packet ending with `rx_crc_ok`=0 sets bit 3, and it is still stored and still sets bit 0. With `cfg_iso`=0, bit 3 is not set.
- R9: When the bank due to be filled is still full, `rx_nak` is 1, and incoming bytes and packet-ends are discarded without changing any bank.
- R10: Writing 1 to bits 0, 1 or 3 has no effect. Writing 0 to bit 3 clears the CRC-error flag.
- R11: A hardware set of the CRC-error flag in the same cycle as a software clear of it leaves the flag at 1.
- R12: `rd_data` shows the owned bank's byte at the read pointer, and each `rd_en` cycle advances the pointer, so bytes come out in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_two_banks | input | 1 | 1 selects two banks, 0 selects one bank |
| cfg_iso | input | 1 | Isochronous mode; enables CRC-error reporting |
| rx_valid | input | 1 | Packet byte present on `rx_data` |
| rx_data | input | DATA_W | Received packet byte |
| rx_end | input | 1 | Packet-end strobe |
| rx_crc_ok | input | 1 | CRC status, sampled with `rx_end` |
| rx_nak | output | 1 | Bank due to be filled is not free |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control word write value |
| ctl_rdata | output | 5 | Control word read value |
| rd_en | input | 1 | Advance the CPU read pointer |
| rd_data | output | DATA_W | Byte at the read pointer of the owned bank |
| rd_count | output | $clog2(BANK_DEPTH)+1 | Byte count of the owned bank |
| rd_bank | output | 1 | Index of the bank the CPU owns |
| irq | output | 1 | Interrupt output |

## Verification
The assertions assume the following about the inputs:
- `rx_end` never arrives in the same cycle as `rx_valid`.
- `cfg_two_banks` and `cfg_iso` change only while `rst_n` is low.
- `rx_crc_ok` is only meaningful with `rx_end`.

The stimulus keeps to these assumptions. Every configuration change happens inside a reset task. Packet bytes and the end strobe are driven on separate falling edges. A packet is offered while `rx_nak` is high only on purpose, to show that it is dropped.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

    typedef enum logic [1:0] {
        OWN_EMPTY = 2'd0,
        OWN_READY = 2'd1,
        OWN_ACKED = 2'd2
    } own_state_t;

    localparam int CTL_W      = 5;
    localparam int BIT_RDY    = 0;
    localparam int BIT_BUSY   = 1;
    localparam int BIT_RDY_IE = 2;
    localparam int BIT_CRC    = 3;
    localparam int BIT_CRC_IE = 4;

endpackage

// File: rtl/rxp_bank_store.sv
module rxp_bank_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       two_banks_i,
    input  logic                       rx_valid_i,
    input  logic [DW-1:0]              rx_data_i,
    input  logic                       rx_end_i,
    input  logic                       release_i,
    input  logic                       release_bank_i,
    input  logic                       rd_bank_i,
    input  logic [$clog2(DEPTH)-1:0]   rd_ptr_i,
    output logic [1:0]                 full_o,
    output logic                       fill_o,
    output logic                       done_o,
    output logic                       nak_o,
    output logic [DW-1:0]              rd_data_o,
    output logic [$clog2(DEPTH):0]     rd_count_o
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic          fill_q;
    logic [CW-1:0] wptr_q;
    logic [DW-1:0] mem [2][DEPTH];
    logic [CW-1:0] cnt [2];
    logic          wr_ok;

    assign nak_o  = full_o[fill_q];
    assign done_o = rx_end_i & ~nak_o;
    assign wr_ok  = rx_valid_i & ~nak_o & (wptr_q < CW'(DEPTH));
    assign fill_o = fill_q;

    // Fill pointer and write index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= 1'b0;
            wptr_q <= '0;
        end else if (rx_end_i) begin
            wptr_q <= '0;
            if (done_o) fill_q <= two_banks_i ? ~fill_q : 1'b0;
        end else if (wr_ok) begin
            wptr_q <= wptr_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[fill_q][wptr_q[PW-1:0]] <= rx_data_i;
    end

    // Per-bank occupancy and byte count
    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic          full_q;
        logic [CW-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                full_q <= 1'b0;
                cnt_q  <= '0;
            end else if (done_o && fill_q == b[0]) begin
                full_q <= 1'b1;
                cnt_q  <= wptr_q;
            end else if (release_i && release_bank_i == b[0]) begin
                full_q <= 1'b0;
            end
        end
        assign full_o[b] = full_q;
        assign cnt[b]    = cnt_q;
    end

    assign rd_data_o  = mem[rd_bank_i][rd_ptr_i];
    assign rd_count_o = cnt[rd_bank_i];

    a_r9_refused_end_keeps_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_end_i && nak_o) |=> (fill_q == $past(fill_q)));
    a_r7_single_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!two_banks_i) |-> (fill_q == 1'b0));
endmodule

// File: rtl/rxp_own_fsm.sv
module rxp_own_fsm
    import rxp_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      two_banks_i,
    input  logic                      done_i,
    input  logic                      done_bank_i,
    input  logic [1:0]                full_i,
    input  logic                      clr_rdy_i,
    input  logic                      clr_busy_i,
    input  logic                      rd_en_i,
    input  logic [$clog2(DEPTH):0]    rd_count_i,
    output logic                      own_o,
    output logic                      release_o,
    output logic                      rdy_o,
    output logic                      busy_o,
    output logic [$clog2(DEPTH)-1:0]  rd_ptr_o
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    own_state_t    state_q, state_d;
    logic          own_q, own_d;
    logic [CW-1:0] rptr_q;
    logic          other;
    logic          other_full;

    assign other      = ~own_q;
    assign other_full = two_banks_i & (full_i[other] | (done_i & (done_bank_i == other)));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OWN_EMPTY;
            own_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            own_q   <= own_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OWN_EMPTY: if (done_i && done_bank_i == own_q) state_d = OWN_READY;
            OWN_READY: begin
                if (clr_busy_i)     state_d = other_full ? OWN_READY : OWN_EMPTY;
                else if (clr_rdy_i) state_d = OWN_ACKED;
            end
            OWN_ACKED: if (clr_busy_i) state_d = other_full ? OWN_READY : OWN_EMPTY;
            default:   state_d = OWN_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        release_o = clr_busy_i && (state_q != OWN_EMPTY);
        own_d     = (release_o && two_banks_i) ? other : own_q;
        rdy_o     = (state_q == OWN_READY);
        busy_o    = (state_q != OWN_EMPTY);
        own_o     = own_q;
        rd_ptr_o  = rptr_q[PW-1:0];
    end

    // CPU read pointer
    always_ff @(posedge clk) begin
        if (!rst_n || release_o)                rptr_q <= '0;
        else if (rd_en_i && rptr_q < rd_count_i) rptr_q <= rptr_q + CW'(1);
    end

    a_r2_fill_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OWN_EMPTY && done_i && done_bank_i == own_q) |=> (state_q == OWN_READY));
    a_r4_ack_keeps_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OWN_READY && clr_rdy_i && !clr_busy_i) |=> (state_q == OWN_ACKED && full_i[own_q]));
    a_r5_release_switches: assert property (@(posedge clk) disable iff (!rst_n)
        (release_o && two_banks_i) |=> (own_q != $past(own_q)));
    a_r6_busy_matches_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != OWN_EMPTY) |-> full_i[own_q]);
endmodule

// File: rtl/rxp_pipe_ctrl.sv
module rxp_pipe_ctrl
    import rxp_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int BANK_DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_two_banks,
    input  logic                          cfg_iso,
    input  logic                          rx_valid,
    input  logic [DATA_W-1:0]             rx_data,
    input  logic                          rx_end,
    input  logic                          rx_crc_ok,
    output logic                          rx_nak,
    input  logic                          ctl_we,
    input  logic [4:0]                    ctl_wdata,
    output logic [4:0]                    ctl_rdata,
    input  logic                          rd_en,
    output logic [DATA_W-1:0]             rd_data,
    output logic [$clog2(BANK_DEPTH):0]   rd_count,
    output logic                          rd_bank,
    output logic                          irq
);
    localparam int PW = $clog2(BANK_DEPTH);

    logic [1:0]    full;
    logic          fill, done, release_b, own, rdy, busy;
    logic [PW-1:0] rd_ptr;
    logic          clr_rdy, clr_busy, crc_set;
    logic          crc_q, rdy_ie_q, crc_ie_q;

    assign clr_rdy  = ctl_we & ~ctl_wdata[BIT_RDY];
    assign clr_busy = ctl_we & ~ctl_wdata[BIT_BUSY];
    assign crc_set  = done & cfg_iso & ~rx_crc_ok;

    rxp_bank_store #(.DW(DATA_W), .DEPTH(BANK_DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .two_banks_i(cfg_two_banks),
        .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_end_i(rx_end),
        .release_i(release_b), .release_bank_i(own),
        .rd_bank_i(own), .rd_ptr_i(rd_ptr),
        .full_o(full), .fill_o(fill), .done_o(done), .nak_o(rx_nak),
        .rd_data_o(rd_data), .rd_count_o(rd_count)
    );

    rxp_own_fsm #(.DEPTH(BANK_DEPTH)) u_fsm (
        .clk(clk), .rst_n(rst_n), .two_banks_i(cfg_two_banks),
        .done_i(done), .done_bank_i(fill), .full_i(full),
        .clr_rdy_i(clr_rdy), .clr_busy_i(clr_busy),
        .rd_en_i(rd_en), .rd_count_i(rd_count),
        .own_o(own), .release_o(release_b), .rdy_o(rdy), .busy_o(busy),
        .rd_ptr_o(rd_ptr)
    );

    // CRC-error flag and interrupt enables; hardware set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q    <= 1'b0;
            rdy_ie_q <= 1'b0;
            crc_ie_q <= 1'b0;
        end else begin
            if (crc_set)                             crc_q <= 1'b1;
            else if (ctl_we && !ctl_wdata[BIT_CRC])  crc_q <= 1'b0;
            if (ctl_we) begin
                rdy_ie_q <= ctl_wdata[BIT_RDY_IE];
                crc_ie_q <= ctl_wdata[BIT_CRC_IE];
            end
        end
    end

    always_comb begin
        ctl_rdata             = '0;
        ctl_rdata[BIT_RDY]    = rdy;
        ctl_rdata[BIT_BUSY]   = busy;
        ctl_rdata[BIT_RDY_IE] = rdy_ie_q;
        ctl_rdata[BIT_CRC]    = crc_q;
        ctl_rdata[BIT_CRC_IE] = crc_ie_q;
        irq                   = (rdy & rdy_ie_q) | (crc_q & crc_ie_q);
        rd_bank               = own;
    end

    a_r8_iso_bad_crc_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cfg_iso && !rx_crc_ok) |=> (crc_q && rdy_ie_q == $past(ctl_we ? ctl_wdata[BIT_RDY_IE] : rdy_ie_q)));
    a_r10_crc_holds_without_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_q && !ctl_we) |=> crc_q);
endmodule

// File: tb/sim_rxp_pipe_ctrl.sv
module sim_rxp_pipe_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_two_banks = 1'b1, cfg_iso = 1'b1;
    logic       rx_valid = 1'b0, rx_end = 1'b0, rx_crc_ok = 1'b1;
    logic [7:0] rx_data = '0;
    logic       rx_nak;
    logic       ctl_we = 1'b0;
    logic [4:0] ctl_wdata = '0;
    logic [4:0] ctl_rdata;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] rd_count;
    logic       rd_bank, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    rxp_pipe_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_two_banks(cfg_two_banks), .cfg_iso(cfg_iso),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end), .rx_crc_ok(rx_crc_ok),
        .rx_nak(rx_nak), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .rd_en(rd_en), .rd_data(rd_data), .rd_count(rd_count), .rd_bank(rd_bank), .irq(irq)
    );

    // {len[13:9], crc_ok[8], base[7:0]}
    localparam logic [13:0] VEC [6] = '{
        {5'd4,  1'b1, 8'h10},
        {5'd1,  1'b0, 8'hA0},
        {5'd16, 1'b1, 8'h30},
        {5'd7,  1'b0, 8'h55},
        {5'd0,  1'b1, 8'h00},
        {5'd3,  1'b1, 8'hF0}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic two, input logic iso);
        rst_n = 1'b0;
        cfg_two_banks = two;
        cfg_iso = iso;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_pkt(input int len, input logic [7:0] base, input logic ok);
        for (int i = 0; i < len; i++) begin
            rx_valid = 1'b1;
            rx_data  = base + 8'(i);
            @(negedge clk);
        end
        rx_valid  = 1'b0;
        rx_end    = 1'b1;
        rx_crc_ok = ok;
        @(negedge clk);
        rx_end    = 1'b0;
        rx_crc_ok = 1'b1;
    endtask

    task automatic ctl_write(input logic [4:0] v);
        ctl_we = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic read_byte(output logic [7:0] d);
        d = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        logic [7:0] b;
        do_reset(1'b1, 1'b1);
        check("R1 ctl_rdata", ctl_rdata, 0);
        check("R1 irq", irq, 0);
        check("R1 rd_bank", rd_bank, 0);
        check("R1 rd_count", rd_count, 0);
        check("R1 rx_nak", rx_nak, 0);

        // Table walk: two banks, isochronous
        for (int k = 0; k < 6; k++) begin
            int len;
            logic ok;
            logic [7:0] base;
            len  = int'(VEC[k][13:9]);
            ok   = VEC[k][8];
            base = VEC[k][7:0];
            send_pkt(len, base, ok);
            check("R2 ready+busy", int'(ctl_rdata[1:0]), 3);
            check("R2 rd_count", rd_count, len);
            check("R8 crc flag", ctl_rdata[3], !ok);
            check("R7 bank order", rd_bank, k % 2);
            for (int i = 0; i < len; i++) begin
                read_byte(b);
                check("R12 byte", b, int'(base + 8'(i)));
            end
            ctl_write(5'b00000);
            check("R5 bank switched", rd_bank, (k + 1) % 2);
            check("R6 empty reload", ctl_rdata, 0);
        end

        // Ignore 1s, interrupt, acknowledge
        do_reset(1'b1, 1'b1);
        ctl_write(5'b01111);
        check("R10 ones ignored", int'(ctl_rdata[3:0]), 4'b0100);
        check("R3 irq idle", irq, 0);
        send_pkt(2, 8'h01, 1'b1);
        check("R3 irq on ready", irq, 1);
        ctl_write(5'b00110);
        check("R4 ready cleared", ctl_rdata[0], 0);
        check("R4 busy kept", ctl_rdata[1], 1);
        check("R3 irq after ack", irq, 0);
        check("R4 data kept", rd_data, 8'h01);
        check("R4 count kept", rd_count, 2);

        // Second bank fills, both full, refuse, reload
        send_pkt(3, 8'h20, 1'b1);
        check("R7 flags unchanged", int'(ctl_rdata[1:0]), 2);
        check("R9 nak both full", rx_nak, 1);
        send_pkt(5, 8'h70, 1'b1);
        ctl_write(5'b00101);
        check("R6 reload ready+busy", int'(ctl_rdata[1:0]), 3);
        check("R5 rd_bank", rd_bank, 1);
        check("R9 dropped packet", rd_count, 3);
        check("R5 pointer at 0", rd_data, 8'h20);
        check("R9 nak clears", rx_nak, 0);
        check("R3 irq reloaded", irq, 1);
        ctl_write(5'b00100);
        check("R6 empty after release", int'(ctl_rdata[1:0]), 0);
        check("R7 back to bank 0", rd_bank, 0);

        // Same-cycle set and clear of CRC flag
        do_reset(1'b1, 1'b1);
        ctl_write(5'b10011);
        rx_valid = 1'b1; rx_data = 8'h9C;
        @(negedge clk);
        rx_valid = 1'b0; rx_end = 1'b1; rx_crc_ok = 1'b0;
        ctl_we = 1'b1; ctl_wdata = 5'b10011;
        @(negedge clk);
        rx_end = 1'b0; rx_crc_ok = 1'b1; ctl_we = 1'b0;
        check("R11 set beats clear", ctl_rdata[3], 1);
        check("R8 stored with bad crc", ctl_rdata[0], 1);
        check("R3 irq from crc", irq, 1);
        ctl_write(5'b10011);
        check("R10 crc cleared", ctl_rdata[3], 0);
        check("R3 irq low", irq, 0);

        // Single bank, non-isochronous
        do_reset(1'b0, 1'b0);
        send_pkt(2, 8'h44, 1'b0);
        check("R8 no crc in bulk", ctl_rdata[3], 0);
        check("R8 ready set", ctl_rdata[0], 1);
        check("R9 nak single full", rx_nak, 1);
        ctl_write(5'b00000);
        check("R7 single stays 0", rd_bank, 0);
        check("R5 single released", int'(ctl_rdata[1:0]), 0);
        send_pkt(1, 8'h66, 1'b1);
        check("R7 single bank reuse", rd_bank, 0);
        check("R12 single data", rd_data, 8'h66);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule